// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a serial bit stream that arrives one bit per clock cycle. It raises a match flag each time the three most recent bits read 1, 1, 0 in arrival order, with the oldest bit first. Every three-bit window is tested, and consecutive windows share two bits. A match can therefore be followed by a new match three bits later, and the trailing bits of one candidate can start the next one.

Two build-time parameters choose how the block is made. `MEALY_OUT` picks the output timing. When it is 0, the flag is decoded from the stored state alone, so it comes up in the cycle after the completing 0 has been clocked in. When it is 1, the flag is decoded from the stored state together with the present input bit, so it comes up during the cycle in which that 0 is presented, one clock earlier. `COMPACT_STATE` picks how the state is held. When it is 0, the block keeps a literal record of the last three bits. When it is 1, the block keeps a four-state count of how much of the pattern has been seen. In the same output mode, both state styles give the same flag sequence.

A synchronous active-high reset returns the block to its empty state.

Top module: `opd_top`

## Requirements
- R1: Exactly one input bit is taken on every rising clock edge while reset is low. Windows overlap. The flag is never high in two consecutive cycles. The stream 1,1,0,1,1,0 flags twice: after its third bit and after its sixth bit.
- R2: Streams that contain no 1,1,0 window never raise the flag. Examples are all-zero streams and alternating 1,0,1,0,... streams.
- R3: With `MEALY_OUT`=0, `match_o` is high in a cycle only if the three bits clocked in on the preceding three edges were 1, 1, 0, oldest first.
- R4: With `MEALY_OUT`=1, `match_o` is high in a cycle only if `din_i` is 0 in that cycle and the two bits clocked in on the preceding two edges were 1 and 1.
- R5: For any input stream, `COMPACT_STATE`=1 gives the same `match_o` sequence as `COMPACT_STATE`=0 with the same `MEALY_OUT`.
- R6: The bit after a completed pattern starts a new candidate. In the stream 1,1,0,1,1,0 the fourth and fifth bits begin the second match.
- R7: A run of two or more 1s followed by a 0 flags exactly once, at the 0. This holds for 1,1,1,0 and 1,1,1,1,0. The flag is raised whenever its window condition holds.
- R8: A rising edge with `rst` high clears the state. After reset, no flag appears until enough bits have arrived: three bits with `MEALY_OUT`=0, or two bits plus a 0 on the input with `MEALY_OUT`=1. Bits received before the reset never count toward a match. `match_o` is 0 in the first cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 1 | Serial input bit, one per clock |
| match_o | output | 1 | Pattern flag, timed according to `MEALY_OUT` |

## Verification
The bench builds all four parameter combinations side by side: `MEALY_OUT` set to 0 and 1, each with `COMPACT_STATE` set to 0 and 1. All four receive the same stimulus. Each output-timing variant is compared against its own expected cycle: Mealy builds are sampled in the low phase of the clock before the edge that consumes the bit, and Moore builds are sampled after that edge. Because one expected stream serves both state styles, any difference between the history register and the progress machine appears directly. This covers overlaps, runs of ones, and a reset placed just after a partial 1,1 prefix.

// File: rtl/opd_pkg.sv
package opd_pkg;

  // Number of bits in the detected window
  localparam int WIN_W = 3;

  // Progress through the 1,1,0 pattern
  typedef enum logic [1:0] {
    PR_NONE = 2'd0,  // nothing useful seen
    PR_ONE  = 2'd1,  // last bit was a 1
    PR_TWO  = 2'd2,  // last two bits were 1,1
    PR_DONE = 2'd3   // last three bits were 1,1,0
  } progress_e;

endpackage

// File: rtl/opd_history_state.sv
module opd_history_state
  import opd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic early_hit_o,
  output logic late_hit_o
);

  logic [WIN_W-1:0] hist_q;

  // newest bit enters at the low end
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[WIN_W-2:0], din_i};
    end
  end

  // state ends in 1,1 and the incoming bit is 0
  assign early_hit_o = hist_q[1] & hist_q[0] & ~din_i;
  // stored window equals 1,1,0
  assign late_hit_o  = hist_q[2] & hist_q[1] & ~hist_q[0];

endmodule

// File: rtl/opd_progress_state.sv
module opd_progress_state
  import opd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic early_hit_o,
  output logic late_hit_o
);

  progress_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PR_NONE: st_d = din_i ? PR_ONE : PR_NONE;
      PR_ONE:  st_d = din_i ? PR_TWO : PR_NONE;
      PR_TWO:  st_d = din_i ? PR_TWO : PR_DONE;
      PR_DONE: st_d = din_i ? PR_ONE : PR_NONE;
      default: st_d = PR_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PR_NONE;
    end else begin
      st_q <= st_d;
    end
  end

  // only the PR_TWO -> PR_DONE step carries a match
  assign early_hit_o = (st_q == PR_TWO) & ~din_i;
  assign late_hit_o  = (st_q == PR_DONE);

endmodule

// File: rtl/opd_top.sv
module opd_top #(
  parameter int MEALY_OUT     = 0,
  parameter int COMPACT_STATE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic match_o
);

  logic early_hit;
  logic late_hit;

  generate
    if (COMPACT_STATE != 0) begin : g_compact
      opd_progress_state u_state (
        .clk         (clk),
        .rst         (rst),
        .din_i       (din_i),
        .early_hit_o (early_hit),
        .late_hit_o  (late_hit)
      );
    end else begin : g_history
      opd_history_state u_state (
        .clk         (clk),
        .rst         (rst),
        .din_i       (din_i),
        .early_hit_o (early_hit),
        .late_hit_o  (late_hit)
      );
    end
  endgenerate

  generate
    if (MEALY_OUT != 0) begin : g_mealy
      assign match_o = early_hit;
    end else begin : g_moore
      assign match_o = late_hit;
    end
  endgenerate

endmodule

// File: rtl/opd_checker.sv
module opd_checker #(
  parameter int MEALY_OUT = 0
) (
  input logic clk,
  input logic rst,
  input logic din,
  input logic match
);

  // bits taken since reset, saturating at 3
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 2'd0;
    end else if (seen != 2'd3) begin
      seen <= seen + 2'd1;
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    match |=> !match);

  generate
    if (MEALY_OUT != 0) begin : g_mealy_chk
      assert_hit_shape_R4: assert property (@(posedge clk) disable iff (rst)
        match |-> (!din && $past(din) && $past(din, 2)));

      assert_hit_complete_R7: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && !din && $past(din) && $past(din, 2)) |-> match);

      assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (seen < 2'd2) |-> !match);
    end else begin : g_moore_chk
      assert_hit_shape_R3: assert property (@(posedge clk) disable iff (rst)
        match |-> (!$past(din) && $past(din, 2) && $past(din, 3)));

      assert_hit_complete_R7: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && !$past(din) && $past(din, 2) && $past(din, 3)) |-> match);

      assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (seen != 2'd3) |-> !match);
    end
  endgenerate

endmodule

bind opd_top opd_checker #(.MEALY_OUT(MEALY_OUT)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .din   (din_i),
  .match (match_o)
);

// File: tb/opd_top_tb_top.sv
module opd_top_tb_top;

  localparam int NVAR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b1;
  logic [NVAR-1:0] match;

  always #10 clk = ~clk;  // 50 MHz

  // variant v: MEALY_OUT = v%2, COMPACT_STATE = v/2
  for (genvar v = 0; v < NVAR; v++) begin : g_var
    opd_top #(.MEALY_OUT(v % 2), .COMPACT_STATE(v / 2)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .din_i   (din),
      .match_o (match[v])
    );
  end

  typedef struct {
    bit    early_exp;  // expected Mealy flag while the bit is presented
    bit    late_exp;   // expected Moore flag after the bit is clocked
    string req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [1:0] mh = 2'b00;
  int mcnt = 0;
  bit done = 0;

  task automatic do_reset();
    item_t it;
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    it.early_exp = 1'b0;
    it.late_exp  = 1'b0;
    it.req = "R8";
    q.push_back(it);
    mh = 2'b00;
    mcnt = 0;
  endtask

  task automatic apply_bit(input bit b, input string req);
    item_t it;
    bit hit;
    @(negedge clk);
    rst = 1'b0;
    din = b;
    hit = (mcnt >= 2) && (mh == 2'b11) && !b;
    it.early_exp = hit;
    it.late_exp  = hit;
    it.req = req;
    q.push_back(it);
    mh = {mh[0], b};
    mcnt++;
  endtask

  task automatic apply_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) begin
      apply_bit(s[i] == "1", req);
    end
  endtask

  // monitor: Mealy builds sampled before the edge, Moore builds after it
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() != 0) begin
        it = q[0];
        for (int v = 1; v < NVAR; v += 2) begin
          checks++;
          if (match[v] !== it.early_exp) begin
            fails++;
            $display("FAIL %s variant %0d (early) actual %0b expected %0b",
                     it.req, v, match[v], it.early_exp);
          end
        end
        @(posedge clk);
        #5;
        for (int v = 0; v < NVAR; v += 2) begin
          checks++;
          if (match[v] !== it.late_exp) begin
            fails++;
            $display("FAIL %s variant %0d (late) actual %0b expected %0b",
                     it.req, v, match[v], it.late_exp);
          end
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();                   // R8: reset state, flag low
    apply_str("000", "R8");
    apply_str("110", "R3");       // R3/R4 timing per mode
    apply_str("0000", "R2");
    apply_str("1010101", "R2");
    apply_str("0", "R4");
    apply_str("110110", "R1");
    apply_str("0110110", "R6");
    apply_str("01110", "R7");
    apply_str("011110", "R7");
    apply_str("11", "R8");        // partial prefix, then reset
    do_reset();
    apply_str("0", "R8");         // old 1,1 must not count
    apply_str("1", "R8");
    do_reset();
    apply_str("10", "R8");
    apply_str("110", "R4");
    lfsr = 16'hACE1;
    for (int i = 0; i < 240; i++) begin
      apply_bit(lfsr[0], "R5");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    apply_str("000", "R2");
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule